// File: doc/BRIEF.md
# Multi-Context Lookup-Table Cell

This block is a single reconfigurable logic cell. It holds several complete lookup-table programs at once. A context number is broadcast to every cell in an array, and each cell uses the program it stores under that number. Because every cell keeps its own copy of each program, two cells can do different work under the same context number. The cell therefore changes its function in one clock, without a slow reprogramming phase.

Each stored word is the truth table of a lookup table plus one mode bit. The mode bit picks either a purely combinational output or a registered output whose state feeds back into the table address. A wide load port writes a whole word into any context in one cycle. The cell keeps computing while the load happens, so a controller can prepare the next program in the background.

Top module: `mclut_cell`

## Requirements
- R1: The cell stores NUM_CTX (default 4) words of 2**LUT_INPUTS + 1 bits (default 17). Bits [15:0] are the truth table, where bit i is the output for table address i. Bit 16 is the mode bit: 0 means combinational output, 1 means registered output.
- R2: `ctx_sel` is sampled on each rising clock edge. The output uses the newly selected context from the cycle after that edge. Before the edge it still uses the previous context.
- R3: When the active context has mode 0, `cell_out` equals the truth-table bit addressed by `nbr_in`, with address bit k taken from `nbr_in[k]`.
- R4: On a rising edge where `ld_we` is 1, `ld_word` is written into context `ld_ctx`. A write to a context that is not active leaves `cell_out` unchanged.
- R5: A write to the active context does not affect `cell_out` during the write cycle. The new contents drive `cell_out` from the cycle after the write edge.
- R6: When the active context has mode 1, table address bit 0 is the cell's state bit and address bits 3..1 come from `nbr_in[3:1]`. The state bit loads the table result on every rising edge, and `cell_out` shows the state bit.
- R7: The state bit holds its value while the active context has mode 0, and it keeps that value across context switches.
- R8: Driving `rst_n` low clears all contexts, the active context number and the state bit at once, so `cell_out` reads 0. The cell leaves reset on the second rising edge after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the cell |
| ctx_sel | input | 2 | Broadcast context number |
| nbr_in | input | 4 | Table address inputs from neighbouring cells |
| ld_we | input | 1 | Load strobe |
| ld_ctx | input | 2 | Context written by the load |
| ld_word | input | 17 | Full context word: mode bit and truth table |
| cell_out | output | 1 | Cell result |

## Verification
The bench builds the cell with its default parameters: four-input tables and four contexts. At that size it can reach every context, with hand-derivable truth tables such as AND, OR, parity and a toggle function. It can also reach every timing case: a switch before and after its edge, writes to active and inactive contexts, and state that survives a round trip through a combinational context. The small address space lets each expected bit be read straight off a 16-bit constant.

// File: rtl/mclut_pkg.sv
package mclut_pkg;

  // Output mode carried in the top bit of every context word.
  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;

endpackage

// File: rtl/mclut_rst_sync.sv
module mclut_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/mclut_ctx_store.sv
module mclut_ctx_store #(
  parameter int NUM_CTX = 4,
  parameter int CFG_W   = 17,
  localparam int AW     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [CFG_W-1:0] wr_word,
  input  logic [AW-1:0]    rd_idx,
  output logic [CFG_W-1:0] rd_word
);

  logic [CFG_W-1:0] words [NUM_CTX];

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    logic             hit;
    logic [CFG_W-1:0] word_q;

    assign hit = wr_en && (wr_idx == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (hit) begin
        word_q <= wr_word;
      end
    end

    assign words[g] = word_q;
  end

  assign rd_word = words[rd_idx];

endmodule

// File: rtl/mclut_lut_eval.sv
module mclut_lut_eval #(
  parameter int N_IN   = 4,
  localparam int TT_W  = 1 << N_IN
) (
  input  logic [TT_W-1:0] table_i,
  input  logic [N_IN-1:0] addr_i,
  output logic            bit_o
);

  always_comb begin
    bit_o = table_i[addr_i];
  end

endmodule

// File: rtl/mclut_cell.sv
module mclut_cell #(
  parameter int LUT_INPUTS = 4,
  parameter int NUM_CTX    = 4,
  localparam int TT_BITS   = 1 << LUT_INPUTS,
  localparam int CFG_W     = TT_BITS + 1,
  localparam int CTX_AW    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTX_AW-1:0] ctx_sel,
  input  logic [LUT_INPUTS-1:0] nbr_in,
  input  logic              ld_we,
  input  logic [CTX_AW-1:0] ld_ctx,
  input  logic [CFG_W-1:0]  ld_word,
  output logic              cell_out
);

  import mclut_pkg::*;

  localparam int MODE_BIT = CFG_W - 1;

  logic                  rst_core_n;
  logic [CTX_AW-1:0]     active_d, active_q;
  logic [CFG_W-1:0]      cfg_word;
  out_mode_e             cfg_mode;
  logic                  reg_mode;
  logic [LUT_INPUTS-1:0] lut_addr;
  logic                  lut_bit;
  logic                  state_d, state_q, state_en;

  mclut_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  mclut_ctx_store #(
    .NUM_CTX (NUM_CTX),
    .CFG_W   (CFG_W)
  ) i_store (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (ld_we),
    .wr_idx  (ld_ctx),
    .wr_word (ld_word),
    .rd_idx  (active_q),
    .rd_word (cfg_word)
  );

  // Context and mode decode
  always_comb begin
    active_d = ctx_sel;
    cfg_mode = out_mode_e'(cfg_word[MODE_BIT]);
    reg_mode = (cfg_mode == OUT_REG);
  end

  // Table address: in registered mode the state bit replaces address bit 0
  always_comb begin
    lut_addr = nbr_in;
    if (reg_mode) begin
      lut_addr[0] = state_q;
    end
  end

  mclut_lut_eval #(
    .N_IN (LUT_INPUTS)
  ) i_lut (
    .table_i (cfg_word[TT_BITS-1:0]),
    .addr_i  (lut_addr),
    .bit_o   (lut_bit)
  );

  // State next-state logic with explicit enable
  always_comb begin
    state_en = reg_mode;
    state_d  = lut_bit;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      active_q <= '0;
    end else begin
      active_q <= active_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= 1'b0;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_comb begin
    cell_out = reg_mode ? state_q : lut_bit;
  end

endmodule

// File: rtl/mclut_cell_chk.sv
module mclut_cell_chk #(
  parameter int LUT_INPUTS = 4,
  parameter int NUM_CTX    = 4,
  localparam int TT_BITS   = 1 << LUT_INPUTS,
  localparam int CFG_W     = TT_BITS + 1,
  localparam int CTX_AW    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [CTX_AW-1:0]     ctx_sel,
  input logic [CTX_AW-1:0]     active_q,
  input logic [LUT_INPUTS-1:0] nbr_in,
  input logic                  ld_we,
  input logic [CTX_AW-1:0]     ld_ctx,
  input logic [CFG_W-1:0]      ld_word,
  input logic                  reg_mode,
  input logic                  lut_bit,
  input logic                  state_q,
  input logic                  cell_out
);

  logic [TT_BITS-1:0] wr_table_q;

  always_ff @(posedge clk) begin
    wr_table_q <= ld_word[TT_BITS-1:0];
  end

  // R2: a new context number is in use one edge later
  a_r2_ctx_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_sel != active_q) |=> (active_q == $past(ctx_sel)));

  // R5: a combinational-mode write to the context about to be active shows next cycle
  a_r5_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we && (ld_ctx == ctx_sel) && !ld_word[CFG_W-1])
      |=> (cell_out == wr_table_q[nbr_in]));

  // R6: registered contexts load the table result into the state bit
  a_r6_state_update: assert property (@(posedge clk) disable iff (!rst_n)
    reg_mode |=> (state_q == $past(lut_bit)));

  // R7: combinational contexts leave the state bit alone
  a_r7_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_mode |=> $stable(state_q));

  // R8: while reset is held the output reads zero
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r8_reset_quiet: assert (cell_out == 1'b0);
    end
  end

endmodule

bind mclut_cell mclut_cell_chk #(
  .LUT_INPUTS (LUT_INPUTS),
  .NUM_CTX    (NUM_CTX)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .ctx_sel  (ctx_sel),
  .active_q (active_q),
  .nbr_in   (nbr_in),
  .ld_we    (ld_we),
  .ld_ctx   (ld_ctx),
  .ld_word  (ld_word),
  .reg_mode (reg_mode),
  .lut_bit  (lut_bit),
  .state_q  (state_q),
  .cell_out (cell_out)
);

// File: tb/test_mclut_cell.sv
`timescale 1ns/1ps
module test_mclut_cell;

  logic        clk;
  logic        rst_n;
  logic [1:0]  ctx_sel;
  logic [3:0]  nbr_in;
  logic        ld_we;
  logic [1:0]  ld_ctx;
  logic [16:0] ld_word;
  logic        cell_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Vector: {context[6:5], address[4:1], expected[0]}
  // ctx0 = AND (16'h8000), ctx1 = OR (16'hFFFE), ctx2 = parity (16'h6996), ctx3 = 16'hA5C3
  localparam logic [6:0] VEC [10] = '{
    {2'd0, 4'hF, 1'b1},
    {2'd0, 4'h7, 1'b0},
    {2'd1, 4'h0, 1'b0},
    {2'd1, 4'h4, 1'b1},
    {2'd2, 4'h3, 1'b0},
    {2'd2, 4'h7, 1'b1},
    {2'd3, 4'h1, 1'b1},
    {2'd3, 4'h2, 1'b0},
    {2'd3, 4'hF, 1'b1},
    {2'd3, 4'h6, 1'b1}
  };

  mclut_cell i_mclut_cell (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctx_sel  (ctx_sel),
    .nbr_in   (nbr_in),
    .ld_we    (ld_we),
    .ld_ctx   (ld_ctx),
    .ld_word  (ld_word),
    .cell_out (cell_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (cell_out !== exp) begin
      n_fail++;
      $display("FAIL %s: cell_out=%b expected %b", req, cell_out, exp);
    end
  endtask

  task automatic load(input logic [1:0] idx, input logic [16:0] word);
    ld_we   = 1'b1;
    ld_ctx  = idx;
    ld_word = word;
    step();
    ld_we   = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst_n   = 1'b0;
    ctx_sel = 2'd0;
    nbr_in  = 4'hF;
    ld_we   = 1'b0;
    ld_ctx  = 2'd0;
    ld_word = '0;
    step();
    step();
    check("R8", 1'b0);
    rst_n = 1'b1;
    step();
    step();
    step();
    // R8: every context is empty after reset
    ctx_sel = 2'd2;
    step();
    check("R8", 1'b0);

    // R1: program the four contexts, combinational mode
    load(2'd0, {1'b0, 16'h8000});
    load(2'd1, {1'b0, 16'hFFFE});
    load(2'd2, {1'b0, 16'h6996});
    load(2'd3, {1'b0, 16'hA5C3});

    for (int i = 0; i < 10; i++) begin
      ctx_sel = VEC[i][6:5];
      nbr_in  = VEC[i][4:1];
      step();
      check("R1 R3", VEC[i][0]);
    end

    // R2: switch timing
    ctx_sel = 2'd0;
    nbr_in  = 4'hF;
    step();
    check("R3", 1'b1);
    ctx_sel = 2'd1;
    nbr_in  = 4'h4;
    #1;
    check("R2", 1'b0);
    step();
    check("R2", 1'b1);

    // R4: background write to an inactive context
    ld_we   = 1'b1;
    ld_ctx  = 2'd2;
    ld_word = '0;
    step();
    ld_we = 1'b0;
    check("R4", 1'b1);
    ctx_sel = 2'd2;
    nbr_in  = 4'h7;
    step();
    check("R4", 1'b0);

    // R5: write to the active context
    ctx_sel = 2'd1;
    nbr_in  = 4'h4;
    step();
    check("R5", 1'b1);
    ld_we   = 1'b1;
    ld_ctx  = 2'd1;
    ld_word = '0;
    #1;
    check("R5", 1'b1);
    step();
    ld_we = 1'b0;
    check("R5", 1'b0);

    // R6: registered toggle, table = state ^ nbr_in[1]
    load(2'd3, {1'b1, 16'h6666});
    ctx_sel = 2'd3;
    nbr_in  = 4'h2;
    step();
    check("R6", 1'b0);
    step();
    check("R6", 1'b1);
    step();
    check("R6", 1'b0);
    step();
    check("R6", 1'b1);
    nbr_in = 4'h0;
    step();
    check("R6", 1'b1);

    // R7: state kept through a combinational context
    ctx_sel = 2'd0;
    step();
    check("R7", 1'b0);
    step();
    check("R7", 1'b0);
    ctx_sel = 2'd3;
    step();
    check("R7", 1'b1);

    // R8: asynchronous reset mid-run clears state and contexts
    rst_n = 1'b0;
    #1;
    check("R8", 1'b0);
    step();
    rst_n = 1'b1;
    step();
    step();
    step();
    ctx_sel = 2'd3;
    nbr_in  = 4'h2;
    step();
    step();
    check("R8", 1'b0);

    finish_run();
  end

endmodule